// File: doc/BRIEF.md
# Up/Down Wiper Stepping Controller

This block moves four 8-bit wiper codes from pins rather than from a serial bus. A host pulls the active-low chip select down, chooses a channel with a two-bit select, sets a direction level and toggles a step line. Each falling edge of the step line moves the chosen wiper code one count toward 0xFF (direction high) or toward 0x00 (direction low). The code stops at either end and never wraps.

When chip select is released, the level of the step line at that moment decides the outcome. If the step line is high, the write-allow input is high and the shared data-register-select bits are both zero, the chosen channel's current code is committed to that channel's default nonvolatile slot. A self-timed write cycle then starts, and busy stays high for its full length. In every other case nothing is saved, the wiper keeps its new code and the block returns to standby. The nonvolatile slots are modelled as registers with a cycle counter.

While chip select is low, a lock output tells the neighbouring two-wire interface to stay off the registers. All three pin inputs (chip select, step and direction) pass through a two-flop synchroniser before any edge or level is judged.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: After reset every wiper code and every default slot holds INIT_CODE (0x80 by default), busy is 0 and the serial lock is 0.
- R2: While chip select is low, each high-to-low transition of the step input changes the selected wiper code by exactly one: +1 when the direction input is 1 and -1 when it is 0.
- R3: A wiper code at 0xFF stays at 0xFF on an up step, and a code at 0x00 stays at 0x00 on a down step.
- R4: Channel select value 00 picks channel 0, 01 channel 1, 10 channel 2 and 11 channel 3. Channels that are not selected keep their codes. The wiper output packs channel n in bits [8n+7:8n].
- R5: The serial lock output is 1 while the synchronised chip select is low and returns to 0 after it rises.
- R6: While chip select is high, step edges change no wiper code.
- R7: A rising chip select, seen while the step input is high, write-allow is 1, the data-register-select bits are 00 and busy is 0, copies the selected channel's wiper code into that channel's slot. It also raises busy. The slot output packs channel n in bits [8n+7:8n].
- R8: A rising chip select stores nothing if the step input is low, or write-allow is 0, or the data-register-select bits are not 00. Busy stays 0, and the wiper code keeps the value it was stepped to.
- R9: Busy stays high for exactly WRITE_CYCLES clock cycles (64 in the bench) after a store. A store attempted while busy is high is dropped and leaves every slot unchanged.
- R10: The direction input may change while chip select stays low. Each step uses the direction level present at its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select for pin stepping (asynchronous) |
| step_i | input | 1 | Step line; falling edge moves the wiper (asynchronous) |
| dir_i | input | 1 | Direction: 1 up, 0 down (asynchronous) |
| chan_i | input | 2 | Channel select |
| wr_allow_i | input | 1 | Write-allow for nonvolatile stores; 0 blocks all stores |
| slot_sel_i | input | 2 | Data-register-select bits of the shared status register |
| wiper_o | output | 32 | Packed wiper codes, channel n at [8n+7:8n] |
| slot0_o | output | 32 | Packed default-slot contents, channel n at [8n+7:8n] |
| busy_o | output | 1 | Nonvolatile write cycle in progress |
| serial_lock_o | output | 1 | Keeps the two-wire interface disabled |

## Verification
The assertions assume that the channel select, write-allow and slot-select inputs are not synchronised. They must therefore stay steady from before chip select falls until after it rises, and every level on the step and direction inputs must last several system clocks so that it passes the synchroniser. The bench changes inputs only on falling clock edges. It holds each step level for four clocks and sets the channel and the enables before each selection. It reads the outputs only after the synchroniser and register latency has elapsed.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    REL_NONE   = 2'd0,
    REL_COMMIT = 2'd1,
    REL_SKIP   = 2'd2
  } release_kind_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= RST_VAL;
    else     stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= RST_VAL;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/updn_step_core.sv
module updn_step_core #(
  parameter int NUM_CH = 4,
  parameter int CH_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire_i,
  input  logic                     up_i,
  input  logic [CH_W-1:0]          chan_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o
);
  localparam logic [DATA_W-1:0] MAXV = '1;
  localparam logic [DATA_W-1:0] MINV = '0;

  logic [DATA_W-1:0] w_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = fire_i && (chan_i == CH_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q[i] <= INIT_CODE;
      end else if (hit) begin
        if (up_i && (w_q[i] != MAXV))       w_q[i] <= w_q[i] + 1'b1;
        else if (!up_i && (w_q[i] != MINV)) w_q[i] <= w_q[i] - 1'b1;
      end
    end

    assign wiper_o[i*DATA_W +: DATA_W] = w_q[i];

    // R2: a permitted up step adds exactly one
    a_r2_up_one: assert property (@(posedge clk) disable iff (rst)
      (hit && up_i && w_q[i] != MAXV) |=> (w_q[i] == $past(w_q[i]) + 1'b1));
    // R2: a permitted down step subtracts exactly one
    a_r2_down_one: assert property (@(posedge clk) disable iff (rst)
      (hit && !up_i && w_q[i] != MINV) |=> (w_q[i] == $past(w_q[i]) - 1'b1));
    // R3: no wrap at the top
    a_r3_sat_high: assert property (@(posedge clk) disable iff (rst)
      (hit && up_i && w_q[i] == MAXV) |=> (w_q[i] == MAXV));
    // R3: no wrap at the bottom
    a_r3_sat_low: assert property (@(posedge clk) disable iff (rst)
      (hit && !up_i && w_q[i] == MINV) |=> (w_q[i] == MINV));
    // R4: an unselected channel holds
    a_r4_other_hold: assert property (@(posedge clk) disable iff (rst)
      (fire_i && chan_i != CH_W'(i)) |=> $stable(w_q[i]));
  end
endmodule

// File: rtl/updn_store_ctrl.sv
module updn_store_ctrl
  import updn_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_rise_i,
  input  logic                     step_lvl_i,
  input  logic                     wr_allow_i,
  input  logic [SEL_W-1:0]         slot_sel_i,
  input  logic [CH_W-1:0]          chan_i,
  input  logic [NUM_CH*DATA_W-1:0] wiper_i,
  output logic                     req_o,
  output logic [CH_W-1:0]          req_chan_o,
  output logic [DATA_W-1:0]        req_data_o
);
  release_kind_e kind;

  always_comb begin
    kind = REL_NONE;
    if (cs_rise_i) begin
      if (step_lvl_i && wr_allow_i && (slot_sel_i == '0)) kind = REL_COMMIT;
      else                                                 kind = REL_SKIP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o      <= 1'b0;
      req_chan_o <= '0;
      req_data_o <= '0;
    end else begin
      req_o <= (kind == REL_COMMIT);
      if (kind == REL_COMMIT) begin
        req_chan_o <= chan_i;
        req_data_o <= wiper_i[chan_i*DATA_W +: DATA_W];
      end
    end
  end

  // R8: write-allow low never yields a store request
  a_r8_wp_blocks: assert property (@(posedge clk) disable iff (rst)
    (!wr_allow_i) |=> !req_o);
  // R8: step low at release never yields a store request
  a_r8_step_low_blocks: assert property (@(posedge clk) disable iff (rst)
    (!step_lvl_i) |=> !req_o);
endmodule

// File: rtl/updn_nv_model.sv
module updn_nv_model #(
  parameter int NUM_CH = 4,
  parameter int CH_W = 2,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80,
  parameter int WRITE_CYCLES = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic [CH_W-1:0]          chan_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] slot_o,
  output logic                     busy_o
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [DATA_W-1:0] slot_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              accept;

  assign accept = req_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                              slot_q[i] <= INIT_CODE;
      else if (accept && chan_i == CH_W'(i)) slot_q[i] <= data_i;
    end
    assign slot_o[i*DATA_W +: DATA_W] = slot_q[i];
  end

  assign busy_o = busy_q;

  // R7: an accepted request raises busy
  a_r7_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_q) |=> busy_q);
  // R9: slots frozen while a write cycle runs
  a_r9_slots_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(slot_o));
endmodule

// File: rtl/updn_wiper_ctrl.sv
module updn_wiper_ctrl #(
  parameter int CH_W = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WRITE_CYCLES = 64,
  parameter logic [DATA_W-1:0] INIT_CODE = 8'h80,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n_i,
  input  logic                     step_i,
  input  logic                     dir_i,
  input  logic [CH_W-1:0]          chan_i,
  input  logic                     wr_allow_i,
  input  logic [SEL_W-1:0]         slot_sel_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic [NUM_CH*DATA_W-1:0] slot0_o,
  output logic                     busy_o,
  output logic                     serial_lock_o
);
  logic [2:0] raw_in, syn_in;
  logic cs_s, step_s, dir_s;
  logic cs_prev, step_prev;
  logic step_fall, cs_rise, fire;
  logic lock_q;
  logic req;
  logic [CH_W-1:0] req_chan;
  logic [DATA_W-1:0] req_data;

  assign raw_in = {cs_n_i, step_i, dir_i};

  updn_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn_in)
  );

  assign {cs_s, step_s, dir_s} = syn_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      step_prev <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      step_prev <= step_s;
      lock_q    <= !cs_s;
    end
  end

  assign step_fall = step_prev && !step_s;
  assign cs_rise   = !cs_prev && cs_s;
  assign fire      = step_fall && !cs_s;

  updn_step_core #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .INIT_CODE(INIT_CODE)
  ) u_core (
    .clk(clk), .rst(rst), .fire_i(fire), .up_i(dir_s), .chan_i(chan_i),
    .wiper_o(wiper_o)
  );

  updn_store_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_store (
    .clk(clk), .rst(rst), .cs_rise_i(cs_rise), .step_lvl_i(step_s),
    .wr_allow_i(wr_allow_i), .slot_sel_i(slot_sel_i), .chan_i(chan_i),
    .wiper_i(wiper_o), .req_o(req), .req_chan_o(req_chan),
    .req_data_o(req_data)
  );

  updn_nv_model #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .INIT_CODE(INIT_CODE),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_nv (
    .clk(clk), .rst(rst), .req_i(req), .chan_i(req_chan), .data_i(req_data),
    .slot_o(slot0_o), .busy_o(busy_o)
  );

  assign serial_lock_o = lock_q;

  // R5: selection asserts the serial lock on the next cycle
  a_r5_lock_on: assert property (@(posedge clk) disable iff (rst)
    (!cs_s) |=> serial_lock_o);
  // R6: no wiper movement while deselected
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> $stable(wiper_o));
endmodule

// File: tb/updn_wiper_ctrl_bench.sv
module updn_wiper_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, step = 1'b0, dir = 1'b0, wr_allow = 1'b1;
  logic [1:0] chan = 2'd0, slot_sel = 2'd0;
  logic [31:0] wiper, slot0;
  logic busy, lock;
  int errors = 0, checks = 0, busy_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updn_wiper_ctrl u_updn_wiper_ctrl (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .step_i(step), .dir_i(dir),
    .chan_i(chan), .wr_allow_i(wr_allow), .slot_sel_i(slot_sel),
    .wiper_o(wiper), .slot0_o(slot0), .busy_o(busy), .serial_lock_o(lock)
  );

  always @(negedge clk) if (busy) busy_cnt++;

  // {chan, dir, steps, expected code}
  localparam logic [23:0] VEC [6] = '{
    {4'd0, 4'd1, 8'd3, 8'h83},
    {4'd1, 4'd0, 8'd5, 8'h7B},
    {4'd2, 4'd1, 8'd2, 8'h82},
    {4'd3, 4'd0, 8'd1, 8'h7F},
    {4'd0, 4'd0, 8'd3, 8'h80},
    {4'd1, 4'd1, 8'd1, 8'h7C}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      step = 1'b1; wait_n(4);
      step = 1'b0; wait_n(4);
    end
  endtask

  task automatic sel(input logic [1:0] c);
    chan = c; cs_n = 1'b0; wait_n(4);
  endtask

  task automatic rel_nostore();
    step = 1'b0; cs_n = 1'b1; wait_n(6);
  endtask

  task automatic rel_store();
    step = 1'b1; wait_n(4);
    cs_n = 1'b1; wait_n(4);
    step = 1'b0; wait_n(4);
  endtask

  function automatic logic [7:0] code(input int c);
    return wiper[c*8 +: 8];
  endfunction

  function automatic logic [7:0] slot(input int c);
    return slot0[c*8 +: 8];
  endfunction

  initial begin
    wait_n(3); rst = 1'b0; wait_n(5);
    chk("R1 wipers", wiper, 32'h80808080);
    chk("R1 slots", slot0, 32'h80808080);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 lock", {31'd0, lock}, 0);

    sel(2'd0); wait_n(2);
    chk("R5 lock on", {31'd0, lock}, 1);
    rel_nostore();
    chk("R5 lock off", {31'd0, lock}, 0);

    for (int v = 0; v < 6; v++) begin
      dir = VEC[v][16];
      sel(VEC[v][21:20]);
      pulse(int'(VEC[v][15:8]));
      rel_nostore();
      chk("R2 step result", {24'd0, code(int'(VEC[v][21:20]))}, {24'd0, VEC[v][7:0]});
    end
    chk("R4 channel map", wiper, 32'h7F827C80);
    chk("R8 step low no store", slot0, 32'h80808080);

    sel(2'd3); dir = 1'b1; pulse(2); dir = 1'b0; pulse(1); rel_nostore();
    chk("R10 dir change", {24'd0, code(3)}, 32'h80);

    chan = 2'd2; pulse(3); wait_n(4);
    chk("R6 idle steps", wiper, 32'h80827C80);

    sel(2'd1); dir = 1'b1; pulse(200);
    chk("R3 top", {24'd0, code(1)}, 32'hFF);
    dir = 1'b0; pulse(300);
    chk("R3 bottom", {24'd0, code(1)}, 32'h00);
    rel_nostore();
    chk("R3 others", wiper, 32'h80820080);

    busy_cnt = 0;
    sel(2'd2); rel_store();
    chk("R7 stored", {24'd0, slot(2)}, 32'h82);
    chk("R7 busy", {31'd0, busy}, 1);
    wait (!busy); wait_n(2);
    chk("R9 busy length", busy_cnt, 64);

    sel(2'd2); dir = 1'b1; pulse(1); rel_store();
    sel(2'd0); pulse(1); rel_store();
    chk("R9 first kept", {24'd0, slot(2)}, 32'h83);
    chk("R9 dropped", {24'd0, slot(0)}, 32'h80);
    chk("R9 wiper kept", {24'd0, code(0)}, 32'h81);
    wait (!busy); wait_n(2);

    wr_allow = 1'b0;
    sel(2'd3); pulse(1); rel_store();
    chk("R8 wp slot", {24'd0, slot(3)}, 32'h80);
    chk("R8 wp busy", {31'd0, busy}, 0);
    chk("R8 wp wiper", {24'd0, code(3)}, 32'h81);
    wr_allow = 1'b1; slot_sel = 2'b01;
    sel(2'd3); rel_store();
    chk("R8 sel slot", {24'd0, slot(3)}, 32'h80);
    chk("R8 sel busy", {31'd0, busy}, 0);
    slot_sel = 2'b00;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule